// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Bus Controller

This block sits between a synchronous host and an asynchronous byte-wide static memory with a clock/calendar. It drives active-low chip-enable, output-enable and write-enable strobes, a registered address, and a data output with its own output-enable. The data output and the data input meet at a tri-state pad outside the block. The host hands over one read or one write at a time through a valid/ready port. The block turns that request into a bus cycle whose phases are timed by clock-cycle counts set through parameters. It then returns a one-cycle done pulse that carries the read byte and an error bit.

Two supply-monitor flags enter the block through synchronizers. The first reports that the supply has dropped below the write-protect threshold. The second reports that the memory has switched to its backup cell. While the first flag is set, the block starts no bus cycle. It answers every request with an error and stops any cycle already in progress. A two-bit mode output reports normal operation, write protection, or data retention on the backup cell.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A read drives chip enable and output enable low together with the address, keeps write enable high, and never asserts the block's own data-output enable while output enable is low.
- R2: Read data is captured exactly RD = max(T_AA, T_CEA, T_OEA) clock cycles after the strobes fall. The done pulse appears in that capture cycle, carries the byte that the memory presents, and has the error bit at 0.
- R3: In a write, chip enable falls one cycle before write enable. Write enable then stays low for exactly T_DS cycles, and output enable stays high for the whole write.
- R4: Write data is driven from the chip-enable fall and is held unchanged for T_DH cycles after write enable and chip enable rise together. The done pulse follows when the data is released.
- R5: The address does not change while chip enable is low.
- R6: Between any two bus cycles, chip enable and write enable are both high for at least T_WR cycles.
- R7: While the synchronized power-fail flag is set, a request is accepted and answered in the next cycle with a done pulse and the error bit at 1. No strobe falls and memory content does not change.
- R8: If power-fail becomes visible in the same cycle that a read or write would complete, or earlier, all strobes rise together. The done pulse then carries the error bit at 1; the abort takes priority over completion.
- R9: The mode output is 2'b00 for normal, 2'b01 when only power-fail is set, and 2'b10 when power-fail and battery-switch are both set. Battery-switch alone gives 2'b00. The mode follows the inputs three clock edges later (two synchronizer stages and one register).
- R10: Only one request is outstanding. Ready is high only when the block is idle, and it is low in the cycle after a request that starts a bus cycle.
- R11: After synchronous reset, all three strobes are high, the data output is disabled, ready is high and the mode is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Request valid |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write byte |
| host_ready | output | 1 | Block idle, request accepted on this edge |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Captured read byte |
| host_err | output | 1 | Request refused or aborted |
| pfail_i | input | 1 | Supply below write-protect threshold (asynchronous) |
| batt_i | input | 1 | Memory running from backup cell (asynchronous) |
| pwr_mode | output | 2 | 00 normal, 01 write-protected, 10 retention |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DATA_W | Data toward memory |
| mem_dq_oe | output | 1 | Pad output enable for mem_dq_o |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
Two functions can fall in the same cycle. An arriving power-fail abort can meet the cycle in which a read captures its data, and it can meet the cycle in which a write window closes. The bench raises power-fail in the cycle after acceptance. With two synchronizer stages, the lock then becomes visible exactly on the capture edge (RD = 3) and exactly on the window-close edge (T_DS = 2). The outcome is judged at the host port: the error bit must be 1, the latency must equal that of a normal completion, and a read of the same address after unlock must show the memory model working again.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WCE    = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RWAIT  = 3'd4,
    ST_RECOV  = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_WPROT  = 2'b01,
    MODE_RETAIN = 2'b10
  } pwr_mode_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_pwr_mon.sv
module sram_pwr_mon
  import sram_bus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pfail_i,
  input  logic      batt_i,
  output logic      lock_o,
  output pwr_mode_t mode_o
);

  logic [SYNC_STAGES-1:0] pf_sh;
  logic [SYNC_STAGES-1:0] bs_sh;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          pf_sh <= '0;
          bs_sh <= '0;
        end else begin
          pf_sh <= pfail_i;
          bs_sh <= batt_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          pf_sh <= '0;
          bs_sh <= '0;
        end else begin
          pf_sh <= {pf_sh[SYNC_STAGES-2:0], pfail_i};
          bs_sh <= {bs_sh[SYNC_STAGES-2:0], batt_i};
        end
      end
    end
  endgenerate

  assign lock_o = pf_sh[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_NORMAL;
    end else if (pf_sh[SYNC_STAGES-1]) begin
      mode_o <= bs_sh[SYNC_STAGES-1] ? MODE_RETAIN : MODE_WPROT;
    end else begin
      mode_o <= MODE_NORMAL;
    end
  end

endmodule

// File: rtl/sram_delay_cnt.sv
module sram_delay_cnt #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_bus_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned T_AA   = 4,
  parameter int unsigned T_CEA  = 4,
  parameter int unsigned T_OEA  = 2,
  parameter int unsigned T_DS   = 3,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ce_n,
  output logic              bus_oe_n,
  output logic              bus_we_n,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_dq_oe,
  input  logic [DATA_W-1:0] bus_dq_i
);

  localparam int unsigned RD_CNT = max2(max2(T_AA, T_CEA), T_OEA);
  localparam int unsigned MAXC   = max2(max2(RD_CNT, T_DS), max2(T_DH, T_WR));
  localparam int unsigned CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

  seq_state_t    state;
  logic          ld;
  logic [CW-1:0] ld_val;
  logic          zero;

  sram_delay_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .zero     (zero)
  );

  assign req_ready = (state == ST_IDLE);

  // counter reload for the phase entered on the coming edge
  always_comb begin
    ld     = 1'b0;
    ld_val = '0;
    case (state)
      ST_IDLE: begin
        if (req_valid && !lock && !req_write) begin
          ld     = 1'b1;
          ld_val = CW'(RD_CNT - 1);
        end
      end
      ST_WCE: begin
        ld     = 1'b1;
        ld_val = lock ? CW'(T_WR - 1) : CW'(T_DS - 1);
      end
      ST_WPULSE: begin
        if (lock) begin
          ld     = 1'b1;
          ld_val = CW'(T_WR - 1);
        end else if (zero) begin
          ld     = 1'b1;
          ld_val = CW'(T_DH - 1);
        end
      end
      ST_WHOLD, ST_RWAIT: begin
        if (lock || zero) begin
          ld     = 1'b1;
          ld_val = CW'(T_WR - 1);
        end
      end
      default: begin
        ld     = 1'b0;
        ld_val = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_addr  <= '0;
      bus_ce_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_dq_o  <= '0;
      bus_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (state != ST_IDLE && state != ST_RECOV && lock) begin
        // abort has priority over any completion in this cycle
        bus_ce_n  <= 1'b1;
        bus_oe_n  <= 1'b1;
        bus_we_n  <= 1'b1;
        bus_dq_oe <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b1;
        state     <= ST_RECOV;
      end else begin
        case (state)
          ST_IDLE: begin
            if (req_valid) begin
              if (lock) begin
                rsp_valid <= 1'b1;
                rsp_err   <= 1'b1;
              end else begin
                bus_addr <= req_addr;
                bus_ce_n <= 1'b0;
                rsp_err  <= 1'b0;
                if (req_write) begin
                  bus_dq_o  <= req_wdata;
                  bus_dq_oe <= 1'b1;
                  state     <= ST_WCE;
                end else begin
                  bus_oe_n <= 1'b0;
                  state    <= ST_RWAIT;
                end
              end
            end
          end
          ST_WCE: begin
            bus_we_n <= 1'b0;
            state    <= ST_WPULSE;
          end
          ST_WPULSE: begin
            if (zero) begin
              bus_we_n <= 1'b1;
              bus_ce_n <= 1'b1;
              state    <= ST_WHOLD;
            end
          end
          ST_WHOLD: begin
            if (zero) begin
              bus_dq_oe <= 1'b0;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              state     <= ST_RECOV;
            end
          end
          ST_RWAIT: begin
            if (zero) begin
              rsp_rdata <= bus_dq_i;
              bus_ce_n  <= 1'b1;
              bus_oe_n  <= 1'b1;
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b0;
              state     <= ST_RECOV;
            end
          end
          ST_RECOV: begin
            if (zero) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_bus_pkg::*;
#(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned T_AA        = 4,
  parameter int unsigned T_CEA       = 4,
  parameter int unsigned T_OEA       = 2,
  parameter int unsigned T_DS        = 3,
  parameter int unsigned T_DH        = 1,
  parameter int unsigned T_WR        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_err,
  input  logic              pfail_i,
  input  logic              batt_i,
  output logic [1:0]        pwr_mode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  logic      lock;
  pwr_mode_t mode;

  sram_pwr_mon #(.SYNC_STAGES(SYNC_STAGES)) u_pwr (
    .clk     (clk),
    .rst     (rst),
    .pfail_i (pfail_i),
    .batt_i  (batt_i),
    .lock_o  (lock),
    .mode_o  (mode)
  );

  assign pwr_mode = mode;

  sram_cycle_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .T_AA   (T_AA),
    .T_CEA  (T_CEA),
    .T_OEA  (T_OEA),
    .T_DS   (T_DS),
    .T_DH   (T_DH),
    .T_WR   (T_WR)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .lock      (lock),
    .req_valid (host_valid),
    .req_write (host_write),
    .req_addr  (host_addr),
    .req_wdata (host_wdata),
    .req_ready (host_ready),
    .rsp_valid (host_done),
    .rsp_rdata (host_rdata),
    .rsp_err   (host_err),
    .bus_addr  (mem_addr),
    .bus_ce_n  (mem_ce_n),
    .bus_oe_n  (mem_oe_n),
    .bus_we_n  (mem_we_n),
    .bus_dq_o  (mem_dq_o),
    .bus_dq_oe (mem_dq_oe),
    .bus_dq_i  (mem_dq_i)
  );

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int unsigned ADDR_W      = 17,
  parameter int unsigned T_WR        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              pfail_i,
  input logic              host_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);

  logic [15:0] hi_run;
  logic [15:0] pf_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= 16'hFFFF;
      pf_run <= '0;
    end else begin
      if (mem_ce_n && mem_we_n) begin
        if (hi_run != 16'hFFFF) hi_run <= hi_run + 16'd1;
      end else begin
        hi_run <= '0;
      end
      if (pfail_i) begin
        if (pf_run != 16'hFFFF) pf_run <= pf_run + 16'd1;
      end else begin
        pf_run <= '0;
      end
    end
  end

  a_r1_no_drive_under_oe: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe);

  a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  a_r3_we_inside_ce: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n);

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r6_recovery_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (hi_run >= T_WR));

  a_r7_lock_holds_ce: assert property (@(posedge clk) disable iff (rst)
    (pfail_i && pf_run > SYNC_STAGES) |-> mem_ce_n);

  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !host_ready);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .T_WR        (T_WR),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pfail_i    (pfail_i),
  .host_ready (host_ready),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb;

  localparam int AW = 17;
  localparam int DW = 8;
  localparam int P_AA = 3, P_CEA = 2, P_OEA = 1;
  localparam int P_DS = 2, P_DH = 2, P_WR = 2;
  localparam int P_RD = 3;  // max of the three access counts

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic          host_valid = 1'b0;
  logic          host_write = 1'b0;
  logic [AW-1:0] host_addr  = '0;
  logic [DW-1:0] host_wdata = '0;
  logic          host_ready, host_done, host_err;
  logic [DW-1:0] host_rdata;
  logic          pfail = 1'b0;
  logic          batt  = 1'b0;
  logic [1:0]    pwr_mode;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  sram_bus_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .T_AA(P_AA), .T_CEA(P_CEA), .T_OEA(P_OEA),
    .T_DS(P_DS), .T_DH(P_DH), .T_WR(P_WR), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_done(host_done),
    .host_rdata(host_rdata), .host_err(host_err),
    .pfail_i(pfail), .batt_i(batt), .pwr_mode(pwr_mode),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory with access-time tracking, sampled at falling edges
  logic [DW-1:0] mem [256];
  int ce_lo = 0, oe_lo = 0, addr_n = 0, wlo = 0, hold_n = 0, hi_n = 1000;
  logic          prev_both = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdat = '0;
  int bad_setup = 0, bad_hold = 0, rec_bad = 0, contention = 0, ce_falls = 0;
  int last_wlo = 0, last_lead = 0;

  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && ce_lo >= P_CEA && oe_lo >= P_OEA
                     && addr_n >= P_AA) ? mem[mem_addr[7:0]] : 8'hEE;

  always @(negedge clk) begin
    if (rst) begin
      ce_lo <= 0; oe_lo <= 0; addr_n <= 0; wlo <= 0; hold_n <= 0;
      prev_both <= 1'b0; hi_n <= 1000;
    end else begin
      ce_lo  <= mem_ce_n ? 0 : ce_lo + 1;
      oe_lo  <= mem_oe_n ? 0 : oe_lo + 1;
      addr_n <= (mem_addr == prev_addr) ? addr_n + 1 : 1;
      prev_addr <= mem_addr;
      if (!mem_ce_n && !mem_oe_n && mem_dq_oe) contention <= contention + 1;
      if (mem_ce_n && mem_we_n) hi_n <= hi_n + 1;
      else begin
        if (hi_n != 0 && hi_n < P_WR) rec_bad <= rec_bad + 1;
        if (hi_n != 0) ce_falls <= ce_falls + 1;
        hi_n <= 0;
      end
      prev_both <= !mem_ce_n && !mem_we_n;
      if (!mem_ce_n && !mem_we_n) begin
        wlo <= wlo + 1;
        if (!mem_oe_n || !mem_dq_oe) bad_setup <= bad_setup + 1;
        waddr <= mem_addr;
        wdat  <= mem_dq_o;
      end else if (prev_both) begin
        last_wlo  <= wlo;
        last_lead <= ce_lo - wlo;
        wlo <= 0;
        if (mem_dq_oe && wlo >= P_DS && mem_dq_o == wdat) begin
          mem[waddr[7:0]] <= wdat;
          hold_n <= 1;
        end else begin
          bad_hold <= bad_hold + 1;
        end
      end else if (hold_n != 0 && hold_n < P_DH) begin
        if (!mem_dq_oe || mem_dq_o != wdat) bad_hold <= bad_hold + 1;
        hold_n <= hold_n + 1;
      end else begin
        hold_n <= 0;
      end
    end
  end

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit pf_hit, input bit locked,
                       output logic [DW-1:0] rd, output bit er, output int lat);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    if (pf_hit) pfail = 1'b1;
    if (!locked) chk("R10 ready low while busy", host_ready, 0);
    lat = 1;
    while (!host_done) begin
      @(negedge clk);
      lat++;
    end
    rd = host_rdata;
    er = host_err;
  endtask

  function automatic logic [7:0] pat(input int a, input int pass);
    return (pass == 0) ? 8'((a * 37 + 11) ^ 8'h5A) : 8'((a * 13 + 200) ^ 8'hC3);
  endfunction

  bit done_flag = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd;
    bit er;
    int lat;
    int falls0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R11 ce_n", mem_ce_n, 1);
    chk("R11 oe_n", mem_oe_n, 1);
    chk("R11 we_n", mem_we_n, 1);
    chk("R11 dq_oe", mem_dq_oe, 0);
    chk("R11 ready", host_ready, 1);
    chk("R11 mode", pwr_mode, 2'b00);

    // single write: timing shape (R3, R4)
    do_op(1'b1, 17'h00010, 8'hA5, 1'b0, 1'b0, rd, er, lat);
    chk("R4 write done latency", lat, P_DS + P_DH + 2);
    chk("R4 write err", er, 0);
    chk("R3 WE low width", last_wlo, P_DS);
    chk("R3 CE leads WE", last_lead, 1);
    // single read: capture timing (R1, R2)
    do_op(1'b0, 17'h00010, 8'h00, 1'b0, 1'b0, rd, er, lat);
    chk("R2 read latency", lat, P_RD + 1);
    chk("R2 read data", rd, 8'hA5);
    chk("R2 read err", er, 0);

    // two sweeps over 256 addresses with distinct patterns and orders
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 256; i++) begin
        int a;
        a = (pass == 0) ? i : 255 - i;
        do_op(1'b1, AW'(a), pat(a, pass), 1'b0, 1'b0, rd, er, lat);
        chk("R4 sweep write err", er, 0);
      end
      for (int i = 0; i < 256; i++) begin
        do_op(1'b0, AW'(i), 8'h00, 1'b0, 1'b0, rd, er, lat);
        chk("R2 sweep read data", rd, pat(i, pass));
      end
    end
    chk("R3 setup/window violations", bad_setup, 0);
    chk("R4 hold violations", bad_hold, 0);
    chk("R1 bus contention", contention, 0);
    chk("R6 recovery violations", rec_bad, 0);

    // abort colliding with read capture (R8)
    do_op(1'b0, 17'h00020, 8'h00, 1'b1, 1'b0, rd, er, lat);
    chk("R8 read abort err", er, 1);
    chk("R8 read abort latency", lat, P_RD + 1);
    repeat (4) @(negedge clk);
    chk("R9 mode write-protect", pwr_mode, 2'b01);
    pfail = 1'b0;
    repeat (6) @(negedge clk);
    // abort colliding with write window close (R8)
    do_op(1'b1, 17'h00021, 8'h77, 1'b1, 1'b0, rd, er, lat);
    chk("R8 write abort err", er, 1);
    chk("R8 write abort latency", lat, P_DS + 2);

    // locked accesses (R7, R9)
    batt = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 mode retention", pwr_mode, 2'b10);
    falls0 = ce_falls;
    do_op(1'b1, 17'h00030, 8'h99, 1'b0, 1'b1, rd, er, lat);
    chk("R7 locked write err", er, 1);
    chk("R7 locked write latency", lat, 1);
    do_op(1'b0, 17'h00030, 8'h00, 1'b0, 1'b1, rd, er, lat);
    chk("R7 locked read err", er, 1);
    repeat (3) @(negedge clk);
    chk("R7 no strobe while locked", ce_falls, falls0);

    pfail = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 battery alone is normal", pwr_mode, 2'b00);
    batt = 1'b0;
    do_op(1'b0, 17'h00030, 8'h00, 1'b0, 1'b0, rd, er, lat);
    chk("R7 locked write left memory", rd, pat(48, 1));
    chk("R7 read after unlock err", er, 0);
    do_op(1'b0, 17'h00020, 8'h00, 1'b0, 1'b0, rd, er, lat);
    chk("R8 read after abort", rd, pat(32, 1));
    do_op(1'b1, 17'h00022, 8'h3C, 1'b0, 1'b0, rd, er, lat);
    do_op(1'b0, 17'h00022, 8'h00, 1'b0, 1'b0, rd, er, lat);
    chk("R5 write then read same address", rd, 8'h3C);
    chk("R6 recovery violations final", rec_bad, 0);
    chk("R1 contention final", contention, 0);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule